// File: doc/BRIEF.md
# Fractional Clock-Rate Scaler

The block reduces the effective rate of a core clock by letting only some of the parent clock cycles through. Time is cut into frames of 32 parent cycles. A 5-bit scaling code selects how many of those cycles are swallowed: with code `c`, exactly `32 - c` cycles per frame carry an asserted clock enable. The enabled cycles are spread as evenly as the frame allows. The effective rate is therefore the parent rate times `(32 - c) / 32`, anywhere from 1/32 up to the full rate.

Software reaches the block through a small memory-mapped register port. A code written to the frequency-control register only waits in a shadow copy. It goes live when software sets a kick bit in a second register. The hardware moves the shadow code into the live setting at the next frame boundary, so no frame ever mixes two ratios. Shortly after that it clears the kick bit. Software learns that the change is done when it reads the kick bit back as zero. The `clk_en` output is meant to qualify the parent clock, for example at a clock-gating cell or as an enable on downstream flops.

Top module: `clk_rate_scaler`

## Requirements
- R1: After reset the live code and the shadow code are 0, the kick bit reads 0, and `clk_en` is high in every cycle.
- R2: The frequency-control register sits at byte address 0x0E0 and holds the shadow code in bits 12:8. A read returns the shadow code in those bits and zeros in every other bit. A write updates only that field.
- R3: The kick register sits at 0x004. Bit 31 is the kick/busy flag. Bits 30:0 are plain storage: every write to 0x004 stores them, and a read returns them as they were last written.
- R4: Writing a new shadow code without a kick leaves the `clk_en` pattern unchanged.
- R5: A write to 0x004 with bit 31 set, made while the flag is clear, sets the flag from the next cycle. The shadow code becomes the live code from the first cycle of the next frame.
- R6: The flag stays set through the boundary cycle and through the first cycle of the frame that uses the new code. It reads clear from the second cycle of that frame on.
- R7: While the flag is set, a write of 1 to bit 31 is ignored and a write of 0 to bit 31 does not clear it.
- R8: Frames are counted from reset, and phase 0 is the first cycle after reset is released. In the frame phase `p` (0..31) with live code `c` and `m = 32 - c`, `clk_en` is high exactly when `floor((p+1)m/32) > floor(pm/32)`. This gives exactly `m` enabled cycles per frame.
- R9: With code 31, a frame has exactly one enabled cycle, and it falls in phase 31. With code 0, every cycle is enabled.
- R10: Reads from any other address return 0, and writes to any other address change no state.
- R11: A code written in the boundary cycle (phase 31) of a frame whose kick is pending is not part of that commit. It stays in the shadow register, and the previous shadow value goes live.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Parent clock |
| rst_n | input | 1 | Synchronous reset, active low |
| reg_wr | input | 1 | Register write strobe, taken at the rising edge |
| reg_addr | input | 12 | Register byte address, for reads and writes |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from `reg_addr` |
| clk_en | output | 1 | Clock enable for the reduced-rate core clock |

## Verification
Two kinds of event can land in the same cycle as the frame-boundary commit: a write of a new shadow code, and a kick issued while the clear is still pending. The bench places a code write exactly in phase 31 of a frame whose kick is pending. It then judges the result from the enable count of the next frame and from the shadow readback. The old code must go live, and the new code must stay in the shadow register. The bench also issues a kick in the first cycle of the new frame, while the flag still reads set. That kick must be dropped, which shows up as the flag reading clear one cycle later.

// File: rtl/crs_pkg.sv
// Package: shared constants of the clock-rate scaler.
// Assumes byte addressing and a 32-bit register port.
package crs_pkg;
    localparam int          CRS_CODE_W   = 5;
    localparam int          CRS_ADDR_W   = 12;
    localparam int          CRS_DATA_W   = 32;
    localparam logic [11:0] CRS_FREQ_OFS = 12'h0E0;
    localparam logic [11:0] CRS_KICK_OFS = 12'h004;
    localparam int          CRS_CODE_LSB = 8;
endpackage

// File: rtl/crs_regs.sv
// crs_regs: register port of the scaler.
// It holds the shadow code and the spare kick-register bits, builds the read data,
// and raises a one-cycle kick request when software sets the kick bit while idle.
// Assumes single-cycle writes and combinational reads.
module crs_regs
    import crs_pkg::*;
#(
    parameter int ADDR_W   = CRS_ADDR_W,
    parameter int DATA_W   = CRS_DATA_W,
    parameter int CODE_W   = CRS_CODE_W,
    parameter int CODE_LSB = CRS_CODE_LSB
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              busy,
    output logic [CODE_W-1:0] pend_code,
    output logic              kick_req,
    output logic [DATA_W-1:0] rdata
);
    localparam int FLAG_BIT = DATA_W - 1;

    logic              hit_freq;
    logic              hit_kick;
    logic [DATA_W-2:0] spare_q;

    // Decode the two register addresses.
    assign hit_freq = (addr == ADDR_W'(CRS_FREQ_OFS));
    assign hit_kick = (addr == ADDR_W'(CRS_KICK_OFS));

    // A kick is accepted only while no earlier kick is still pending.
    assign kick_req = wr && hit_kick && wdata[FLAG_BIT] && !busy;

    // Store the shadow code and the plain bits of the kick register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_code <= '0;
            spare_q   <= '0;
        end else if (wr) begin
            if (hit_freq) pend_code <= wdata[CODE_LSB +: CODE_W];
            if (hit_kick) spare_q   <= wdata[DATA_W-2:0];
        end
    end

    // Build the read data from the addressed register.
    always_comb begin
        rdata = '0;
        if (hit_freq)      rdata[CODE_LSB +: CODE_W] = pend_code;
        else if (hit_kick) rdata = {busy, spare_q};
    end
endmodule

// File: rtl/crs_kick.sv
// crs_kick: commit handshake of the scaler.
// It sets the busy flag on a kick request and copies the shadow code into the live
// code at a frame end. The flag clears one cycle after that frame end.
// Assumes kick_req never arrives while busy is set.
module crs_kick #(
    parameter int CODE_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              kick_req,
    input  logic              frame_end,
    input  logic [CODE_W-1:0] pend_code,
    output logic              busy,
    output logic [CODE_W-1:0] live_code
);
    logic commit;
    logic done_q;

    // A pending kick commits in the last cycle of a frame.
    assign commit = busy && frame_end;

    // Track the flag, the live code and the one-cycle delay before clearing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy      <= 1'b0;
            done_q    <= 1'b0;
            live_code <= '0;
        end else begin
            done_q <= commit;
            if (commit)        live_code <= pend_code;
            if (kick_req)      busy <= 1'b1;
            else if (done_q)   busy <= 1'b0;
        end
    end
endmodule

// File: rtl/crs_swallow.sv
// crs_swallow: the cycle-swallowing enable generator.
// A phase counter splits time into frames of 2**CODE_W cycles. An accumulator
// adds (frame - code) every cycle, and each carry out marks an enabled cycle.
// Assumes code changes only at a frame end; the accumulator is zero at every
// frame start.
module crs_swallow #(
    parameter int CODE_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] live_code,
    output logic              clk_en,
    output logic              frame_end,
    output logic [CODE_W-1:0] phase,
    output logic [CODE_W-1:0] acc
);
    localparam int FRAME = 1 << CODE_W;

    logic [CODE_W:0] mult;
    logic [CODE_W:0] sum;

    // Number of enabled cycles per frame, from 1 up to FRAME.
    assign mult      = (CODE_W+1)'(FRAME) - {1'b0, live_code};
    assign sum       = {1'b0, acc} + mult;
    assign clk_en    = sum[CODE_W];
    assign frame_end = (phase == {CODE_W{1'b1}});

    // Advance the frame phase and the remainder of the accumulator.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= '0;
            acc   <= '0;
        end else begin
            phase <= phase + 1'b1;
            acc   <= sum[CODE_W-1:0];
        end
    end
endmodule

// File: rtl/clk_rate_scaler.sv
// clk_rate_scaler: top level of the fractional clock-rate scaler.
// It ties together the register port, the commit handshake and the enable generator.
// Assumes every input is synchronous to clk.
module clk_rate_scaler
    import crs_pkg::*;
#(
    parameter int ADDR_W = CRS_ADDR_W,
    parameter int DATA_W = CRS_DATA_W,
    parameter int CODE_W = CRS_CODE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              clk_en
);
    logic [CODE_W-1:0] pend_code;
    logic [CODE_W-1:0] live_code;
    logic [CODE_W-1:0] phase;
    logic [CODE_W-1:0] acc;
    logic              kick_req;
    logic              busy;
    logic              frame_end;

    crs_regs #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CODE_W(CODE_W), .CODE_LSB(CRS_CODE_LSB)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
        .busy(busy), .pend_code(pend_code), .kick_req(kick_req), .rdata(reg_rdata)
    );

    crs_kick #(.CODE_W(CODE_W)) u_kick (
        .clk(clk), .rst_n(rst_n), .kick_req(kick_req), .frame_end(frame_end),
        .pend_code(pend_code), .busy(busy), .live_code(live_code)
    );

    crs_swallow #(.CODE_W(CODE_W)) u_swallow (
        .clk(clk), .rst_n(rst_n), .live_code(live_code), .clk_en(clk_en),
        .frame_end(frame_end), .phase(phase), .acc(acc)
    );
endmodule

// File: rtl/crs_checker.sv
// crs_checker: temporal properties of clk_rate_scaler, bound to its top level.
// Assumes reset is held low for at least two clock edges.
module crs_checker #(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32,
    parameter int CODE_W = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wr,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [DATA_W-1:0] reg_wdata,
    input logic              clk_en,
    input logic              busy,
    input logic [CODE_W-1:0] live_code,
    input logic [CODE_W-1:0] phase,
    input logic [CODE_W-1:0] acc
);
    // An accepted kick raises the flag in the next cycle.
    p_kick_sets_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == ADDR_W'(12'h004) && reg_wdata[DATA_W-1] && !busy) |=> busy);

    // The live code changes only across a frame boundary.
    p_frame_commit_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (live_code != $past(live_code)) |-> ($past(phase) == {CODE_W{1'b1}}));

    // The flag drops only at the edge that ends phase 0.
    p_clear_timing_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (phase == CODE_W'(1)));

    // Every frame starts with an empty accumulator, so frames do not leak into each other.
    p_frame_aligned_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == '0) |-> (acc == '0));

    // Code 0 gives the full rate.
    p_full_rate_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (live_code == '0) |-> clk_en);

    // Code 31 enables only the last cycle of a frame.
    p_single_cycle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (live_code == {CODE_W{1'b1}} && clk_en) |-> (phase == {CODE_W{1'b1}}));
endmodule

bind clk_rate_scaler crs_checker #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CODE_W(CODE_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .clk_en(clk_en), .busy(busy), .live_code(live_code),
    .phase(phase), .acc(acc)
);

// File: tb/clk_rate_scaler_tb.sv
// clk_rate_scaler_tb: directed bench, one task per scenario.
module clk_rate_scaler_tb;
    localparam logic [11:0] FREQ = 12'h0E0;
    localparam logic [11:0] KICK = 12'h004;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [11:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        clk_en;

    int checks = 0;
    int bad = 0;
    int cyc = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    // Bench-side cycle count since reset release; the frame phase is cyc % 32.
    always @(posedge clk) cyc <= rst_n ? cyc + 1 : 0;

    clk_rate_scaler u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .clk_en(clk_en)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=0x%08h expected=0x%08h at cyc %0d", req, act, exp, cyc);
        end
    endtask

    // Called at a negedge; waits for a negedge in the given phase.
    task automatic wait_phase(input int p);
        while (cyc % 32 != p) @(negedge clk);
    endtask

    // Write in the current cycle; returns at the next negedge.
    task automatic bus_wr(input logic [11:0] a, input logic [31:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic bus_rd(input logic [11:0] a, output logic [31:0] d);
        reg_addr = a;
        #0.5;
        d = reg_rdata;
    endtask

    // Check one full frame against the even-spread rule and its enable count (R8).
    task automatic check_frame(input int code, input string req);
        int m = 32 - code;
        int n = 0;
        wait_phase(0);
        for (int p = 0; p < 32; p++) begin
            logic exp_en = (((p + 1) * m) / 32) != ((p * m) / 32);
            check(req, {31'b0, clk_en}, {31'b0, exp_en});
            n += int'(clk_en);
            @(negedge clk);
        end
        check({req, " count"}, n, m);
    endtask

    task automatic t_reset;
        logic [31:0] d;
        bus_rd(FREQ, d); check("R1 code", d, 32'h0);
        bus_rd(KICK, d); check("R1 kick", d, 32'h0);
        check_frame(0, "R1 full rate");
    endtask

    task automatic t_regs;
        logic [31:0] d;
        bus_wr(FREQ, 32'hFFFF_FFFF);
        bus_rd(FREQ, d); check("R2 field only", d, 32'h0000_1F00);
        bus_wr(FREQ, 32'h0000_05AB);
        bus_rd(FREQ, d); check("R2 code 5", d, 32'h0000_0500);
        bus_wr(KICK, 32'h1234_5678);
        bus_rd(KICK, d); check("R3 spare bits", d, 32'h1234_5678);
        bus_wr(12'h100, 32'hFFFF_FFFF);
        bus_rd(12'h100, d); check("R10 unmapped read", d, 32'h0);
        bus_rd(FREQ, d); check("R10 freq kept", d, 32'h0000_0500);
        bus_rd(KICK, d); check("R10 kick kept", d, 32'h1234_5678);
    endtask

    task automatic t_no_kick;
        check_frame(0, "R4 no kick");
    endtask

    task automatic t_kick;
        logic [31:0] d;
        wait_phase(10);
        bus_wr(KICK, 32'h8000_0055);
        bus_rd(KICK, d); check("R5 flag set", d, 32'h8000_0055);
        wait_phase(31);
        bus_rd(KICK, d); check("R6 set at boundary", d[31], 1'b1);
        @(negedge clk);
        bus_rd(KICK, d); check("R6 set in phase 0", d[31], 1'b1);
        @(negedge clk);
        bus_rd(KICK, d); check("R6 clear in phase 1", d[31], 1'b0);
        check_frame(5, "R5 R8 code 5");
    endtask

    task automatic t_busy_ignore;
        logic [31:0] d;
        bus_wr(FREQ, 32'd20 << 8);
        wait_phase(3);
        bus_wr(KICK, 32'h8000_0000);
        wait_phase(7);
        bus_wr(KICK, 32'h0000_0000);
        bus_rd(KICK, d); check("R7 zero write keeps flag", d, 32'h8000_0000);
        wait_phase(0);
        bus_wr(KICK, 32'h8000_0001);
        bus_rd(KICK, d); check("R7 kick while busy dropped", d, 32'h0000_0001);
        check_frame(20, "R8 code 20");
    endtask

    task automatic t_boundary;
        logic [31:0] d;
        bus_wr(FREQ, 32'd31 << 8);
        bus_wr(KICK, 32'h8000_0000);
        wait_phase(31);
        bus_wr(FREQ, 32'd12 << 8);
        check_frame(31, "R11 R9 old code live");
        bus_rd(FREQ, d); check("R11 shadow kept", d, 32'd12 << 8);
        bus_wr(KICK, 32'h8000_0000);
        check_frame(12, "R11 R8 code 12");
    endtask

    task automatic t_back_to_full;
        logic [31:0] d;
        bus_wr(FREQ, 32'h0);
        bus_wr(KICK, 32'h8000_0000);
        check_frame(0, "R9 full rate again");
        bus_rd(KICK, d); check("R6 idle after", d[31], 1'b0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_regs();
        t_no_kick();
        t_kick();
        t_busy_ignore();
        t_boundary();
        t_back_to_full();
        finished = 1;
        $display("  test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    end
endmodule